// File: doc/BRIEF.md
# Serial Port Low-Power Entry and Start-Edge Wake Controller

This block sits beside a serial port and governs what happens to it when the processor stops. When a halt or an idle request arrives while the core is running, it puts the port's registers into a known state in one clock. The read-only status bits are cleared. The transmit-empty flag is set. The transmit shift register is filled with ones. Writable control bits and the transmit buffer keep their contents. The block also holds the port's control/status register, its transmit buffer and its transmit shift register, so that this reinitialisation is observable at its ports.

While stopped, the block watches the receive-data pin through a two-stage synchroniser. A start edge on that pin wakes the core only when the wake-enable bit allows it. The wake-edge bit selects which direction of edge counts. A qualified edge produces a single wake pulse. After a halt with a crystal oscillator, the run-enable output is then held low for a fixed settling delay. After an idle, or when no crystal is used, run-enable returns on the following cycle.

Top module: `lp_serial_wake`

## Requirements
- R1: After reset, run_en is 1, wake_pulse is 0, csr_val is 0, tx_empty is 1, tsft_val is all ones and tbuf_val is 0.
- R2: A halt_req or idle_req seen at a rising edge while running makes run_en 0 from that edge on.
- R3: At low-power entry the read-only bits of csr_val (bits 7:4) become 0, even when hw_ro_set targets them in the same cycle. The read/write bits (3:0) keep their value, or take a write made in the same cycle.
- R4: At low-power entry tx_empty becomes 1 and tsft_val becomes all ones.
- R5: Low-power entry leaves tbuf_val unchanged.
- R6: A csr write changes only bits 3:0, and hw_ro_set sets only bits 7:4. A tbuf write clears tx_empty. tsft_load copies tbuf_val into tsft_val and sets tx_empty.
- R7: Only bit 3 of wake_en enables pin wake. An edge that arrives while that bit is 0 is ignored and leaves nothing pending, even once the bit is later set.
- R8: Bit 3 of wake_edge selects the edge: 1 selects high-to-low, 0 selects low-to-high. The other direction does not wake.
- R9: A qualified pin change yields wake_pulse high for exactly one cycle, registered at the third rising clock edge after the change.
- R10: After a halt (alone or together with idle) with xtal_mode 1, run_en rises exactly 256 cycles after the wake pulse.
- R11: After an idle, or a halt with xtal_mode 0, run_en rises on the cycle after the wake pulse.
- R12: halt_req and idle_req have no effect during the settling delay.
- R13: Pin edges while running produce no wake pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Request to enter halt |
| idle_req | input | 1 | Request to enter idle |
| xtal_mode | input | 1 | 1 when a crystal oscillator is in use |
| rx_pin | input | 1 | Asynchronous receive-data pin |
| wake_en | input | 8 | Wake-enable register; bit 3 enables the pin |
| wake_edge | input | 8 | Wake-edge register; bit 3 selects the falling edge |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Control/status write data |
| hw_ro_set | input | 8 | Datapath set pulses for the read-only status bits |
| tbuf_we | input | 1 | Transmit buffer write strobe |
| tbuf_wdata | input | 8 | Transmit buffer write data |
| tsft_load | input | 1 | Move the transmit buffer into the shift register |
| wake_pulse | output | 1 | One-cycle wake request |
| run_en | output | 1 | Core may execute |
| csr_val | output | 8 | Control/status register value |
| tx_empty | output | 1 | Transmit buffer empty flag |
| tbuf_val | output | 8 | Transmit buffer value |
| tsft_val | output | 8 | Transmit shift register value |

## Verification
Low-power entry can share a clock with ordinary register traffic: a software csr write, a datapath read-only set pulse and a transmit buffer write. The bench raises halt_req in the same cycle as all three. It then judges that the read-only bits come out cleared, that the writable bits hold the new write, that the buffer holds the new data and that tx_empty is still forced to 1. A second collision comes from halt and idle requests that land inside the settling window. Here the bench checks that run_en still rises exactly 256 cycles after the wake pulse.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_STOP   = 2'd1,
        PS_RESUME = 2'd2,
        PS_SETTLE = 2'd3
    } pwr_state_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit <= 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/lpw_rx_edge.sv
module lpw_rx_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain[0] = pin;
        for (int i = 1; i < CHAIN_W; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{chain: '1};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise =  sync_q.chain[SYNC_STAGES-1] & ~sync_q.chain[SYNC_STAGES];
    assign fall = ~sync_q.chain[SYNC_STAGES-1] &  sync_q.chain[SYNC_STAGES];

endmodule

// File: rtl/lpw_pwr_ctrl.sv
module lpw_pwr_ctrl
    import lpw_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic idle_req,
    input  logic xtal_mode,
    input  logic edge_hit,
    output logic enter_lp,
    output logic stopped,
    output logic wake_pulse,
    output logic run_en
);
    localparam int unsigned CNT_W = cnt_width(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        pwr_state_e       state;
        logic             from_halt;
        logic [CNT_W-1:0] cnt;
        logic             wake;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  enter_d;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.wake = 1'b0;
        enter_d     = 1'b0;
        unique case (ctrl_q.state)
            PS_RUN: begin
                if (halt_req || idle_req) begin
                    enter_d          = 1'b1;
                    ctrl_d.state     = PS_STOP;
                    ctrl_d.from_halt = halt_req;
                end
            end
            PS_STOP: begin
                if (edge_hit) begin
                    ctrl_d.wake = 1'b1;
                    if (ctrl_q.from_halt && xtal_mode) begin
                        ctrl_d.state = PS_SETTLE;
                        ctrl_d.cnt   = CNT_LOAD;
                    end else begin
                        ctrl_d.state = PS_RESUME;
                    end
                end
            end
            PS_RESUME: begin
                ctrl_d.state = PS_RUN;
            end
            PS_SETTLE: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.state = PS_RUN;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            default: ctrl_d.state = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: PS_RUN, from_halt: 1'b0, cnt: '0, wake: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign enter_lp   = enter_d;
    assign stopped    = (ctrl_q.state == PS_STOP);
    assign wake_pulse = ctrl_q.wake;
    assign run_en     = (ctrl_q.state == PS_RUN);

    // R9: the wake request never lasts more than one cycle
    a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R13: a wake pulse only follows a cycle spent stopped
    a_r13_wake_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> $past(ctrl_q.state == PS_STOP));

    // R2: run enable only drops because of a low-power request
    a_r2_run_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_en) |-> $past(halt_req || idle_req));

    // R11: fast resume path returns to run one cycle after the pulse
    a_r11_fast_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && ctrl_q.state == PS_RESUME) |=> run_en);

    // R10: settling path keeps the core held just after the pulse
    a_r10_no_early_run: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && ctrl_q.state == PS_SETTLE) |=> !run_en);

    // R10: expiry of the settle count releases the core
    a_r10_settle_end: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == PS_SETTLE && ctrl_q.cnt == '0) |=> run_en);

    // R12: requests cannot disturb an unexpired settling window
    a_r12_settle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == PS_SETTLE && ctrl_q.cnt != '0) |=> (ctrl_q.state == PS_SETTLE));

endmodule

// File: rtl/lpw_port_regs.sv
module lpw_port_regs #(
    parameter int unsigned          CSR_W   = 8,
    parameter int unsigned          DATA_W  = 8,
    parameter logic [CSR_W-1:0]     RO_MASK = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_lp,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    input  logic [CSR_W-1:0]  hw_ro_set,
    input  logic              tbuf_we,
    input  logic [DATA_W-1:0] tbuf_wdata,
    input  logic              tsft_load,
    output logic [CSR_W-1:0]  csr_val,
    output logic              tx_empty,
    output logic [DATA_W-1:0] tbuf_val,
    output logic [DATA_W-1:0] tsft_val
);
    localparam logic [CSR_W-1:0] RW_MASK = ~RO_MASK;

    typedef struct packed {
        logic [CSR_W-1:0]  csr;
        logic              tbmt;
        logic [DATA_W-1:0] tbuf;
        logic [DATA_W-1:0] tsft;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (csr_we) begin
            regs_d.csr = (regs_q.csr & RO_MASK) | (csr_wdata & RW_MASK);
        end
        regs_d.csr = regs_d.csr | (hw_ro_set & RO_MASK);
        if (tsft_load) begin
            regs_d.tsft = regs_q.tbuf;
            regs_d.tbmt = 1'b1;
        end
        if (tbuf_we) begin
            regs_d.tbuf = tbuf_wdata;
            regs_d.tbmt = 1'b0;
        end
        if (enter_lp) begin
            regs_d.csr  = regs_d.csr & RW_MASK;
            regs_d.tbmt = 1'b1;
            regs_d.tsft = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{csr: '0, tbmt: 1'b1, tbuf: '0, tsft: '1};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign csr_val  = regs_q.csr;
    assign tx_empty = regs_q.tbmt;
    assign tbuf_val = regs_q.tbuf;
    assign tsft_val = regs_q.tsft;

    // R3: read-only status bits are clear right after entry
    a_r3_ro_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        enter_lp |=> ((csr_val & RO_MASK) == '0));

    // R3: writable bits survive entry when nobody writes them
    a_r3_rw_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_lp && !csr_we) |=> ((csr_val & RW_MASK) == $past(csr_val & RW_MASK)));

    // R4: transmit side preset at entry
    a_r4_tx_preset: assert property (@(posedge clk) disable iff (!rst_n)
        enter_lp |=> (tx_empty && tsft_val == '1));

    // R5: transmit buffer untouched by entry
    a_r5_tbuf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_lp && !tbuf_we) |=> $stable(tbuf_val));

    // R6: software cannot write the read-only bits
    a_r6_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && hw_ro_set == '0 && !enter_lp) |=>
            ((csr_val & RO_MASK) == $past(csr_val & RO_MASK)));

endmodule

// File: rtl/lp_serial_wake.sv
module lp_serial_wake
    import lpw_pkg::*;
#(
    parameter int unsigned      CSR_W       = 8,
    parameter int unsigned      DATA_W      = 8,
    parameter int unsigned      WK_W        = 8,
    parameter int unsigned      WAKE_BIT    = 3,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter int unsigned      SETTLE_CYC  = 256,
    parameter logic [CSR_W-1:0] RO_MASK     = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              idle_req,
    input  logic              xtal_mode,
    input  logic              rx_pin,
    input  logic [WK_W-1:0]   wake_en,
    input  logic [WK_W-1:0]   wake_edge,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    input  logic [CSR_W-1:0]  hw_ro_set,
    input  logic              tbuf_we,
    input  logic [DATA_W-1:0] tbuf_wdata,
    input  logic              tsft_load,
    output logic              wake_pulse,
    output logic              run_en,
    output logic [CSR_W-1:0]  csr_val,
    output logic              tx_empty,
    output logic [DATA_W-1:0] tbuf_val,
    output logic [DATA_W-1:0] tsft_val
);
    logic pin_rise;
    logic pin_fall;
    logic stopped;
    logic enter_lp;
    logic edge_sel;
    logic edge_hit;
    logic unused_wake_bits;

    lpw_rx_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (rx_pin),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign edge_sel = wake_edge[WAKE_BIT] ? pin_fall : pin_rise;
    assign edge_hit = stopped && wake_en[WAKE_BIT] && edge_sel;
    assign unused_wake_bits = ^{wake_en, wake_edge};

    lpw_pwr_ctrl #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_pwr_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .idle_req   (idle_req),
        .xtal_mode  (xtal_mode),
        .edge_hit   (edge_hit),
        .enter_lp   (enter_lp),
        .stopped    (stopped),
        .wake_pulse (wake_pulse),
        .run_en     (run_en)
    );

    lpw_port_regs #(
        .CSR_W   (CSR_W),
        .DATA_W  (DATA_W),
        .RO_MASK (RO_MASK)
    ) u_port_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_lp   (enter_lp),
        .csr_we     (csr_we),
        .csr_wdata  (csr_wdata),
        .hw_ro_set  (hw_ro_set),
        .tbuf_we    (tbuf_we),
        .tbuf_wdata (tbuf_wdata),
        .tsft_load  (tsft_load),
        .csr_val    (csr_val),
        .tx_empty   (tx_empty),
        .tbuf_val   (tbuf_val),
        .tsft_val   (tsft_val)
    );

    // R7: a wake needs the enable bit in the cycle the edge is judged
    a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> $past(wake_en[WAKE_BIT]));

    // R13: entering low power and waking never coincide
    a_r13_no_wake_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        enter_lp |=> !wake_pulse);

endmodule

// File: tb/test_lp_serial_wake.sv
module test_lp_serial_wake;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0;
    logic       idle_req = 1'b0;
    logic       xtal_mode = 1'b0;
    logic       rx_pin = 1'b1;
    logic [7:0] wake_en = 8'h00;
    logic [7:0] wake_edge = 8'h00;
    logic       csr_we = 1'b0;
    logic [7:0] csr_wdata = 8'h00;
    logic [7:0] hw_ro_set = 8'h00;
    logic       tbuf_we = 1'b0;
    logic [7:0] tbuf_wdata = 8'h00;
    logic       tsft_load = 1'b0;
    logic       wake_pulse;
    logic       run_en;
    logic [7:0] csr_val;
    logic       tx_empty;
    logic [7:0] tbuf_val;
    logic [7:0] tsft_val;

    int n_checks = 0;
    int n_fail   = 0;

    lp_serial_wake i_lp_serial_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .idle_req   (idle_req),
        .xtal_mode  (xtal_mode),
        .rx_pin     (rx_pin),
        .wake_en    (wake_en),
        .wake_edge  (wake_edge),
        .csr_we     (csr_we),
        .csr_wdata  (csr_wdata),
        .hw_ro_set  (hw_ro_set),
        .tbuf_we    (tbuf_we),
        .tbuf_wdata (tbuf_wdata),
        .tsft_load  (tsft_load),
        .wake_pulse (wake_pulse),
        .run_en     (run_en),
        .csr_val    (csr_val),
        .tx_empty   (tx_empty),
        .tbuf_val   (tbuf_val),
        .tsft_val   (tsft_val)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter_lp(input logic h, input logic i);
        halt_req = h;
        idle_req = i;
        step(1);
        halt_req = 1'b0;
        idle_req = 1'b0;
    endtask

    task automatic count_wakes(input int n, output int seen);
        seen = 0;
        for (int k = 0; k < n; k++) begin
            step(1);
            if (wake_pulse) seen++;
        end
    endtask

    // drive the pin and expect the pulse at the third rising edge (R9)
    task automatic pin_wake(input logic level);
        rx_pin = level;
        step(2);
        chk("R9", wake_pulse, 1'b0, "no pulse before third edge");
        step(1);
        chk("R9", wake_pulse, 1'b1, "pulse at third edge");
    endtask

    task automatic t_reset;
        chk("R1", run_en, 1'b1, "run_en after reset");
        chk("R1", wake_pulse, 1'b0, "wake after reset");
        chk("R1", csr_val, 8'h00, "csr after reset");
        chk("R1", tx_empty, 1'b1, "tx_empty after reset");
        chk("R1", tsft_val, 8'hFF, "tsft after reset");
        chk("R1", tbuf_val, 8'h00, "tbuf after reset");
    endtask

    task automatic t_regs_run;
        csr_we = 1'b1; csr_wdata = 8'hA5;
        step(1);
        csr_we = 1'b0;
        chk("R6", csr_val, 8'h05, "write reaches only bits 3:0");
        hw_ro_set = 8'h3C;
        step(1);
        hw_ro_set = 8'h00;
        chk("R6", csr_val, 8'h35, "hw set reaches only bits 7:4");
        tbuf_we = 1'b1; tbuf_wdata = 8'h3C;
        step(1);
        tbuf_we = 1'b0;
        chk("R6", tbuf_val, 8'h3C, "tbuf written");
        chk("R6", tx_empty, 1'b0, "tbuf write clears empty");
        tsft_load = 1'b1;
        step(1);
        tsft_load = 1'b0;
        chk("R6", tsft_val, 8'h3C, "shift loaded from buffer");
        chk("R6", tx_empty, 1'b1, "load sets empty");
        tbuf_we = 1'b1; tbuf_wdata = 8'h5A;
        step(1);
        tbuf_we = 1'b0;
        chk("R6", tx_empty, 1'b0, "second write clears empty");
    endtask

    // halt with crystal, entry colliding with register traffic
    task automatic t_halt_xtal;
        int seen;
        xtal_mode = 1'b1;
        wake_en   = 8'h08;
        wake_edge = 8'h08;
        hw_ro_set = 8'h40;
        csr_we = 1'b1; csr_wdata = 8'h0A;
        tbuf_we = 1'b1; tbuf_wdata = 8'h77;
        enter_lp(1'b1, 1'b0);
        hw_ro_set = 8'h00; csr_we = 1'b0; tbuf_we = 1'b0;
        chk("R2", run_en, 1'b0, "halt drops run_en");
        chk("R3", csr_val, 8'h0A, "ro cleared, same-cycle write kept");
        chk("R4", tx_empty, 1'b1, "empty forced at entry");
        chk("R4", tsft_val, 8'hFF, "shift preset to ones");
        chk("R5", tbuf_val, 8'h77, "buffer takes same-cycle write only");
        count_wakes(5, seen);
        chk("R9", seen, 0, "no wake while pin idle");
        pin_wake(1'b0);
        step(1);
        chk("R9", wake_pulse, 1'b0, "pulse lasts one cycle");
        chk("R10", run_en, 1'b0, "held during settle");
        halt_req = 1'b1;
        step(1);
        halt_req = 1'b0; idle_req = 1'b1;
        step(1);
        idle_req = 1'b0;
        step(252);
        chk("R12", run_en, 1'b0, "requests ignored, still settling at 255");
        chk("R10", run_en, 1'b0, "not released before 256 cycles");
        step(1);
        chk("R10", run_en, 1'b1, "released 256 cycles after wake");
        step(1);
        chk("R12", run_en, 1'b1, "no late entry from settle-time requests");
        rx_pin = 1'b1;
        count_wakes(5, seen);
        chk("R13", seen, 0, "pin edge while running ignored");
        rx_pin = 1'b0;
        count_wakes(5, seen);
        chk("R13", seen, 0, "falling edge while running ignored");
        rx_pin = 1'b1;
        step(4);
    endtask

    task automatic t_idle_fast;
        xtal_mode = 1'b1;
        hw_ro_set = 8'hF0;
        step(1);
        hw_ro_set = 8'h00;
        enter_lp(1'b0, 1'b1);
        chk("R2", run_en, 1'b0, "idle drops run_en");
        chk("R3", csr_val, 8'h0A, "ro bits cleared by idle, rw kept");
        pin_wake(1'b0);
        chk("R11", run_en, 1'b0, "not running with pulse");
        step(1);
        chk("R11", run_en, 1'b1, "idle resumes next cycle");
        rx_pin = 1'b1;
        step(4);
    endtask

    task automatic t_halt_noxtal;
        xtal_mode = 1'b0;
        enter_lp(1'b1, 1'b0);
        pin_wake(1'b0);
        step(1);
        chk("R11", run_en, 1'b1, "halt without crystal resumes next cycle");
        rx_pin = 1'b1;
        step(4);
    endtask

    task automatic t_enable_gate;
        int seen;
        xtal_mode = 1'b0;
        wake_en = 8'hF7;
        enter_lp(1'b1, 1'b0);
        rx_pin = 1'b0;
        count_wakes(6, seen);
        chk("R7", seen, 0, "edge with bit 3 clear ignored");
        wake_en = 8'h08;
        count_wakes(5, seen);
        chk("R7", seen, 0, "nothing pending after enable");
        chk("R7", run_en, 1'b0, "still stopped");
        rx_pin = 1'b1;
        count_wakes(5, seen);
        chk("R8", seen, 0, "rising edge ignored when falling selected");
        pin_wake(1'b0);
        step(1);
        chk("R7", run_en, 1'b1, "enabled edge wakes");
        rx_pin = 1'b1;
        step(4);
    endtask

    task automatic t_rising;
        int seen;
        wake_edge = 8'hF7;
        xtal_mode = 1'b0;
        enter_lp(1'b1, 1'b0);
        rx_pin = 1'b0;
        count_wakes(6, seen);
        chk("R8", seen, 0, "falling edge ignored when rising selected");
        pin_wake(1'b1);
        step(1);
        chk("R8", run_en, 1'b1, "rising edge wakes");
        wake_edge = 8'h08;
        step(2);
    endtask

    task automatic t_both_req;
        xtal_mode = 1'b1;
        enter_lp(1'b1, 1'b1);
        pin_wake(1'b0);
        step(2);
        chk("R10", run_en, 1'b0, "halt+idle takes settle path");
        step(254);
        chk("R10", run_en, 1'b1, "halt+idle released at 256");
        rx_pin = 1'b1;
        step(4);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regs_run();
        t_halt_xtal();
        t_idle_fast();
        t_halt_noxtal();
        t_enable_gate();
        t_rising();
        t_both_req();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule